// File: doc/BRIEF.md
# Serial Channel-Word Loader with Deferred Transmit Power

This block receives a 16-bit control word for a channel synthesizer over a three-wire serial port: a data line, a serial clock that rests high, and an active-low enable. Each word carries one transmit-power bit followed by a 15-bit channel divide number. The word becomes active only when the enable line returns high. The channel number then goes straight to the divider register. The power bit waits in a holding register and reaches the power-level output only when the radio next enters transmit.

All serial and mode pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected in the system clock domain. A power-down input and a receive/transmit select input set the operating mode. The block also raises a flag whenever the active channel number lies outside the window in which the divider gives a true integer ratio. With a 14.4 MHz reference, the channel number for an RF frequency F in MHz is 20·F − 3008, so 866.05 MHz gives 14313.

Top module: `synth_word_loader`

## Requirements
- R1: The first bit shifted into a word is the power bit. The next 15 bits are the channel number, most significant bit (bit 14) first. After a valid commit, `chan_div` equals those 15 bits.
- R2: Data is sampled on each rising edge of `ser_clk` while `ser_en_n` is low. `ser_clk` rests high between transfers.
- R3: A transfer counts only if `ser_clk` is high when `ser_en_n` falls. Otherwise the word is discarded and `chan_div` and the held power bit keep their values.
- R4: A word is committed on the rising edge of `ser_en_n`. `chan_div` does not change at any other time.
- R5: A power bit of 1 selects low power (`low_power` = 1). A power bit of 0 selects full power (`low_power` = 0).
- R6: A committed power bit leaves `low_power` unchanged until the mode next becomes transmit from any other mode. At that entry it is applied. A word committed in the same cycle as the entry into transmit is applied at that entry.
- R7: `chan_bad` is 1 exactly when `chan_div` is below 3968 or above 32764.
- R8: `mode` is 2'b00 (standby) whenever `pwr_on` is low. Otherwise it is 2'b01 (receive) when `rx_sel` is high and 2'b10 (transmit) when `rx_sel` is low.
- R9: A transfer with fewer or more than 16 serial clock rising edges is discarded, and the previous channel and power values are kept.
- R10: After reset, `chan_div` is 3968, `low_power` is 0, `chan_bad` is 0 and `mode` is standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial word data |
| ser_clk | input | 1 | Serial clock, rests high |
| ser_en_n | input | 1 | Active-low transfer enable; rising edge commits |
| pwr_on | input | 1 | Low forces standby |
| rx_sel | input | 1 | High receive, low transmit |
| chan_div | output | 15 | Active channel divide number |
| low_power | output | 1 | Active transmit power level (1 = low) |
| chan_bad | output | 1 | Channel number outside the legal window |
| mode | output | 2 | 00 standby, 01 receive, 10 transmit |

## Verification
The commit of a word and the entry into transmit can fall in the same system cycle. In that case the new power bit must win over the older held value. The bench provokes this by raising `ser_en_n` and lowering `rx_sel` in the same time step. Both signals go through synchronizers of equal depth, so their edges reach the logic together. The test passes only if `low_power` then shows the bit of the word that has just been committed.

// File: rtl/synth_word_loader.sv
module synth_word_loader #(
  parameter int CH_W   = 15,
  parameter int CH_MIN = 3968,
  parameter int CH_MAX = 32764
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_data,
  input  logic            ser_clk,
  input  logic            ser_en_n,
  input  logic            pwr_on,
  input  logic            rx_sel,
  output logic [CH_W-1:0] chan_div,
  output logic            low_power,
  output logic            chan_bad,
  output logic [1:0]      mode
);
  localparam int WORD_W = CH_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);
  localparam logic [CH_W-1:0] LO = CH_W'(CH_MIN);
  localparam logic [CH_W-1:0] HI = CH_W'(CH_MAX);
  localparam logic [1:0] M_STBY = 2'b00, M_RX = 2'b01, M_TX = 2'b10;
  localparam logic [4:0] SYNC_RST = 5'b01101;

  logic [4:0] s1, s2;
  logic       clk_q, en_q, armed, pend;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shift;
  logic [1:0]        mode_nx;

  wire s_data = s2[4];
  wire s_clk  = s2[3];
  wire s_en   = s2[2];
  wire s_pwr  = s2[1];
  wire s_rx   = s2[0];

  wire clk_rise  = s_clk & ~clk_q;
  wire en_fall   = en_q & ~s_en;
  wire en_rise   = ~en_q & s_en;
  wire commit    = en_rise & armed & (cnt == CNT_FULL);
  wire tx_entry  = (mode_nx == M_TX) && (mode != M_TX);

  assign mode_nx  = !s_pwr ? M_STBY : (s_rx ? M_RX : M_TX);
  assign chan_bad = (chan_div < LO) || (chan_div > HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= SYNC_RST;
      s2 <= SYNC_RST;
      clk_q <= 1'b1;
      en_q  <= 1'b1;
    end else begin
      s1 <= {ser_data, ser_clk, ser_en_n, pwr_on, rx_sel};
      s2 <= s1;
      clk_q <= s_clk;
      en_q  <= s_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      shift <= '0;
    end else if (en_fall) begin
      armed <= s_clk;
      cnt   <= '0;
    end else if (en_rise) begin
      armed <= 1'b0;
    end else if (clk_rise && !s_en && armed) begin
      shift <= {shift[WORD_W-2:0], s_data};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_div  <= LO;
      pend      <= 1'b0;
      low_power <= 1'b0;
      mode      <= M_STBY;
    end else begin
      mode <= mode_nx;
      if (commit) begin
        chan_div <= shift[CH_W-1:0];
        pend     <= shift[WORD_W-1];
      end
      if (tx_entry) low_power <= commit ? shift[WORD_W-1] : pend;
    end
  end

  a_r4_chan_moves_on_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_div) |-> $past(en_rise));
  a_r1_chan_takes_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> chan_div == $past(shift[CH_W-1:0]));
  a_r6_power_moves_at_tx_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(low_power) |-> (mode == M_TX && $past(mode) != M_TX));
  a_r8_standby_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !s_pwr |=> mode == M_STBY);
  a_r9_short_or_long_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && cnt != CNT_FULL) |=> $stable(chan_div));
  a_r3_unarmed_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !armed) |=> $stable(chan_div));
endmodule

// File: tb/synth_word_loader_bench.sv
module synth_word_loader_bench;
  logic clk = 0, rst_n = 0;
  logic ser_data = 0, ser_clk = 1, ser_en_n = 1, pwr_on = 0, rx_sel = 1;
  logic [14:0] chan_div;
  logic low_power, chan_bad;
  logic [1:0] mode;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  synth_word_loader u_synth_word_loader (.*);

  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 15'd14313}, {1'b0, 15'd3968}, {1'b1, 15'd3967}, {1'b0, 15'd32764},
    {1'b1, 15'd32765}, {1'b0, 15'd0},    {1'b0, 15'd21845}, {1'b1, 15'd10922}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] word, input int n, input bit clk_hi);
    if (!clk_hi) begin ser_clk = 0; w(4); end
    ser_en_n = 0; w(4);
    if (!clk_hi) begin ser_clk = 1; w(4); end
    for (int i = 0; i < n; i++) begin
      ser_data = word[15 - (i % 16)];
      ser_clk = 0; w(4);
      ser_clk = 1; w(4);
    end
  endtask

  task automatic finish_send();
    ser_en_n = 1; w(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [14:0] ch_exp;
    logic lp_exp;
    w(3); rst_n = 1; w(2);
    chk(chan_div == 15'd3968, "R10 chan reset", chan_div, 3968);
    chk(low_power == 0, "R10 power reset", low_power, 0);
    chk(chan_bad == 0, "R10 flag reset", chan_bad, 0);
    chk(mode == 2'b00, "R10/R8 standby reset", mode, 0);

    pwr_on = 1; w(6);
    chk(mode == 2'b01, "R8 receive", mode, 1);
    lp_exp = 0;
    for (int k = 0; k < NV; k++) begin
      send(VEC[k], 16, 1);
      chk(chan_div == 15'd3968 || k > 0, "R4 no change before commit", chan_div, 3968);
      finish_send();
      chk(chan_div == VEC[k][14:0], "R1 R2 channel loaded", chan_div, VEC[k][14:0]);
      chk(chan_bad == (VEC[k][14:0] < 3968 || VEC[k][14:0] > 32764), "R7 range flag",
          chan_bad, (VEC[k][14:0] < 3968 || VEC[k][14:0] > 32764));
      chk(low_power == lp_exp, "R6 power deferred", low_power, lp_exp);
      rx_sel = 0; w(6);
      chk(mode == 2'b10, "R8 transmit", mode, 2);
      lp_exp = VEC[k][15];
      chk(low_power == lp_exp, "R5 R6 power applied at tx entry", low_power, lp_exp);
      rx_sel = 1; w(6);
    end

    ch_exp = chan_div;
    send({1'b0, 15'd5000}, 16, 0); finish_send();
    chk(chan_div == ch_exp, "R3 clock low at enable fall", chan_div, ch_exp);
    send({1'b0, 15'd5001}, 15, 1); finish_send();
    chk(chan_div == ch_exp, "R9 fifteen edges", chan_div, ch_exp);
    send({1'b0, 15'd5002}, 17, 1); finish_send();
    chk(chan_div == ch_exp, "R9 seventeen edges", chan_div, ch_exp);
    rx_sel = 0; w(6);
    chk(low_power == lp_exp, "R9 discarded power kept", low_power, lp_exp);
    rx_sel = 1; w(6);

    send({1'b0, 15'd6000}, 16, 1); finish_send();
    send({1'b1, 15'd7000}, 16, 1);
    ser_en_n = 1; rx_sel = 0; w(6);
    chk(chan_div == 15'd7000, "R4 coincident commit", chan_div, 7000);
    chk(low_power == 1, "R6 commit same cycle as tx entry", low_power, 1);

    send({1'b0, 15'd8000}, 16, 1); finish_send();
    chk(low_power == 1, "R6 held while in transmit", low_power, 1);
    pwr_on = 0; w(6);
    chk(mode == 2'b00, "R8 power down overrides tx", mode, 0);
    pwr_on = 1; w(6);
    chk(mode == 2'b10 && low_power == 0, "R6 entry from standby", low_power, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule